// File: doc/BRIEF.md
# Reference-Pixel Cache Tag Resolver

This block is the tag side of a set-associative reference-pixel cache that does not block on misses. Each request carries a block address. The block splits that address into a set index and a tag and compares the tag against every way of the set in one lookup. It then reports the cache line that will hold the data, as a set and a way. A hit is passed to the read queue only. A miss takes a line at once. The line is the lowest-numbered invalid way of the set or, if the set is full, the way that the set's rotating pointer names. The miss sends a fill request to memory and also puts an entry in the read queue, marked as waiting for the fill.

The tag is written in the same cycle the miss is accepted. A later request for the same block therefore resolves as a hit on that way while its fill is still in flight. Replacement is first-in-first-out within each set: hits never move the pointer. The default geometry is 16 kB of 64-byte lines, organised as four ways by 64 sets.

Top module: `refcache_tag_resolver`

## Requirements
- R1: After reset every way of every set is invalid, `rdq_valid_o` and `mem_valid_o` are low, and `req_ready_o` is high while `rdq_ready_i` and `mem_ready_i` are high.
- R2: The set index is bits [5:0] of the block address and the tag is bits [19:6]. The same tag in two different sets occupies separate lines.
- R3: An accepted request whose tag matches a valid way of its set produces, one cycle later, a read-queue entry with `rdq_fill_o` = 0, the request's set and the matching way, and no memory request.
- R4: An accepted request that misses produces, one cycle later, a read-queue entry with `rdq_fill_o` = 1 and a memory request with the block address. Both carry the same allocated way.
- R5: The tag is installed when the miss is accepted, so the same block presented in the very next cycle hits on the allocated way and issues no second memory request.
- R6: While a set still has invalid ways, a miss allocates the lowest-numbered invalid way.
- R7: Once a set is full, a miss evicts the way named by that set's 2-bit pointer. The pointer starts at 0 and advances by one, wrapping, on every miss allocation in the set. Hits leave it unchanged.
- R8: Each set has its own valid bits and pointer, so allocation in one set never changes the victim choice of another set.
- R9: `req_ready_o` equals `rdq_ready_i` AND (hit OR `mem_ready_i`). A request that is not accepted produces no output and changes no tag, valid bit or pointer.
- R10: `rdq_valid_o` is high for exactly one cycle, one cycle after each accepted request, and is low otherwise. `mem_valid_o` is high only in such a cycle and only for a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_baddr_i | input | 20 | Block address of the request |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| rdq_ready_i | input | 1 | Read queue can take an entry |
| rdq_valid_o | output | 1 | Read-queue entry pulse |
| rdq_set_o | output | 6 | Set index of the line to read |
| rdq_way_o | output | 2 | Way of the line to read |
| rdq_fill_o | output | 1 | 1: entry waits for a memory fill, 0: line already present |
| mem_ready_i | input | 1 | Memory request path can take a request |
| mem_valid_o | output | 1 | Fill request pulse |
| mem_baddr_o | output | 20 | Block address to fetch |
| mem_way_o | output | 2 | Way that the fill writes (set is the low address bits) |

## Verification
The hazard that matters most is a tag write and a tag lookup landing in the same clock cycle. A miss installs its tag on the edge that ends its accept cycle, and the next request's lookup reads the array right after that edge. The bench presents the same block in two consecutive cycles and expects a miss followed by a hit on the same way with only one memory request. A second overlap comes from a stalled request that already sits on the input while the read queue or memory path withdraws. The bench checks that nothing is issued during the stall, and that a later retry of the same miss gets the way it would have had with no stall.

// File: rtl/refcache_pkg.sv
package refcache_pkg;
  localparam int unsigned DEF_CACHE_BYTES = 16384;
  localparam int unsigned DEF_LINE_BYTES  = 64;
  localparam int unsigned DEF_NUM_WAYS    = 4;
  localparam int unsigned DEF_BADDR_W     = 20;

  typedef enum logic {
    RD_FROM_CACHE = 1'b0,
    RD_AFTER_FILL = 1'b1
  } rd_src_e;
endpackage

// File: rtl/refc_tag_store.sv
module refc_tag_store #(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned TAG_W    = 14,
  parameter int unsigned SET_W    = $clog2(NUM_SETS),
  parameter int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SET_W-1:0]    lk_set_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  input  logic                wr_en_i,
  input  logic [WAY_W-1:0]    wr_way_i,
  output logic                hit_o,
  output logic [WAY_W-1:0]    hit_way_o,
  output logic [NUM_WAYS-1:0] vld_row_o
);
  logic [NUM_SETS-1:0][NUM_WAYS-1:0] vld_q;
  logic [TAG_W-1:0]                  tag_q [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0]               hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[lk_set_i][wr_way_i] <= 1'b1;
  end

  // tag payload needs no reset: qualified by valid
  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[lk_set_i][wr_way_i] <= lk_tag_i;
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end

  assign hit_o     = |hit_vec;
  assign vld_row_o = vld_q[lk_set_i];

  // R3: a block never lives in two ways of a set
  a_r3_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/refc_fifo_victim.sv
module refc_fifo_victim #(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned SET_W    = $clog2(NUM_SETS),
  parameter int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SET_W-1:0]    set_i,
  input  logic [NUM_WAYS-1:0] vld_row_i,
  input  logic                alloc_i,
  output logic [WAY_W-1:0]    vict_way_o
);
  logic [NUM_SETS-1:0][WAY_W-1:0] ptr_q;
  logic                           has_free;
  logic [WAY_W-1:0]               free_way;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (alloc_i) ptr_q[set_i] <= ptr_q[set_i] + WAY_W'(1);
  end

  // lowest invalid way wins
  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!vld_row_i[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
  end

  assign vict_way_o = has_free ? free_way : ptr_q[set_i];

  // R7: pointers only move on allocation
  a_r7_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_i |=> $stable(ptr_q));

  // R6: a valid way is never chosen while an invalid one exists
  a_r6_free_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_row_i != '1) |-> !vld_row_i[vict_way_o]);
endmodule

// File: rtl/refcache_tag_resolver.sv
module refcache_tag_resolver
  import refcache_pkg::*;
#(
  parameter int unsigned CACHE_BYTES = DEF_CACHE_BYTES,
  parameter int unsigned LINE_BYTES  = DEF_LINE_BYTES,
  parameter int unsigned NUM_WAYS    = DEF_NUM_WAYS,
  parameter int unsigned BADDR_W     = DEF_BADDR_W,
  parameter int unsigned SET_W       = $clog2(CACHE_BYTES / LINE_BYTES / NUM_WAYS),
  parameter int unsigned WAY_W       = $clog2(NUM_WAYS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [BADDR_W-1:0] req_baddr_i,
  output logic               req_ready_o,
  input  logic               rdq_ready_i,
  output logic               rdq_valid_o,
  output logic [SET_W-1:0]   rdq_set_o,
  output logic [WAY_W-1:0]   rdq_way_o,
  output logic               rdq_fill_o,
  input  logic               mem_ready_i,
  output logic               mem_valid_o,
  output logic [BADDR_W-1:0] mem_baddr_o,
  output logic [WAY_W-1:0]   mem_way_o
);
  localparam int unsigned NUM_SETS = CACHE_BYTES / LINE_BYTES / NUM_WAYS;
  localparam int unsigned TAG_W    = BADDR_W - SET_W;

  logic [SET_W-1:0]    lk_set;
  logic [TAG_W-1:0]    lk_tag;
  logic                hit;
  logic [WAY_W-1:0]    hit_way, vict_way, sel_way;
  logic [NUM_WAYS-1:0] vld_row;
  logic                accept, alloc;
  rd_src_e             src;

  assign lk_set = req_baddr_i[SET_W-1:0];
  assign lk_tag = req_baddr_i[BADDR_W-1:SET_W];

  refc_tag_store #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W),
    .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_set_i(lk_set), .lk_tag_i(lk_tag),
    .wr_en_i(alloc), .wr_way_i(vict_way),
    .hit_o(hit), .hit_way_o(hit_way), .vld_row_o(vld_row)
  );

  refc_fifo_victim #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(lk_set), .vld_row_i(vld_row), .alloc_i(alloc),
    .vict_way_o(vict_way)
  );

  assign req_ready_o = rdq_ready_i && (hit || mem_ready_i);
  assign accept      = req_valid_i && req_ready_o;
  assign alloc       = accept && !hit;
  assign sel_way     = hit ? hit_way : vict_way;
  assign src         = hit ? RD_FROM_CACHE : RD_AFTER_FILL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdq_valid_o <= 1'b0;
      rdq_set_o   <= '0;
      rdq_way_o   <= '0;
      rdq_fill_o  <= 1'b0;
      mem_valid_o <= 1'b0;
      mem_baddr_o <= '0;
      mem_way_o   <= '0;
    end else begin
      rdq_valid_o <= accept;
      mem_valid_o <= alloc;
      if (accept) begin
        rdq_set_o  <= lk_set;
        rdq_way_o  <= sel_way;
        rdq_fill_o <= (src == RD_AFTER_FILL);
      end
      if (alloc) begin
        mem_baddr_o <= req_baddr_i;
        mem_way_o   <= vict_way;
      end
    end
  end

  // R9: never accept without read-queue room
  a_r9_room_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> rdq_ready_i);

  // R9: a miss waits for the memory path
  a_r9_miss_waits_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit && !mem_ready_i) |-> !req_ready_o);

  // R10: one entry per accepted request, next cycle
  a_r10_entry_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rdq_valid_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !rdq_valid_o);

  // R4: fill request pairs with a waiting read entry on the same way
  a_r4_fill_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (rdq_valid_o && rdq_fill_o && rdq_way_o == mem_way_o));
endmodule

// File: tb/tb_refcache_tag_resolver.sv
module tb_refcache_tag_resolver;
  localparam int BADDR_W = 20;
  localparam int SET_W   = 6;
  localparam int WAY_W   = 2;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               req_valid = 1'b0;
  logic [BADDR_W-1:0] req_baddr = '0;
  logic               rdq_ready = 1'b1;
  logic               mem_ready = 1'b1;
  logic               req_ready_o, rdq_valid_o, rdq_fill_o, mem_valid_o;
  logic [SET_W-1:0]   rdq_set_o;
  logic [WAY_W-1:0]   rdq_way_o, mem_way_o;
  logic [BADDR_W-1:0] mem_baddr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  refcache_tag_resolver dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_baddr_i(req_baddr), .req_ready_o(req_ready_o),
    .rdq_ready_i(rdq_ready), .rdq_valid_o(rdq_valid_o), .rdq_set_o(rdq_set_o),
    .rdq_way_o(rdq_way_o), .rdq_fill_o(rdq_fill_o),
    .mem_ready_i(mem_ready), .mem_valid_o(mem_valid_o),
    .mem_baddr_o(mem_baddr_o), .mem_way_o(mem_way_o)
  );

  function automatic logic [BADDR_W-1:0] mk(input int tag, input int set);
    return {14'(tag), 6'(set)};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input int set, input int fill, input int way,
                           input logic [BADDR_W-1:0] addr);
    check(req, "rdq_valid", int'(rdq_valid_o), 1);
    check(req, "rdq_set", int'(rdq_set_o), set);
    check(req, "rdq_way", int'(rdq_way_o), way);
    check(req, "rdq_fill", int'(rdq_fill_o), fill);
    check(req, "mem_valid", int'(mem_valid_o), fill);
    if (fill != 0) begin
      check(req, "mem_baddr", int'(mem_baddr_o), int'(addr));
      check(req, "mem_way", int'(mem_way_o), way);
    end
  endtask

  // single accepted request, result checked one cycle later
  task automatic issue(input string req, input int tag, input int set,
                       input int fill, input int way);
    logic [BADDR_W-1:0] a;
    a = mk(tag, set);
    @(negedge clk);
    req_valid = 1'b1;
    req_baddr = a;
    #1 check(req, "ready", int'(req_ready_o), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check_out(req, set, fill, way, a);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "rdq_valid after reset", int'(rdq_valid_o), 0);
    check("R1", "mem_valid after reset", int'(mem_valid_o), 0);
    req_baddr = mk(5, 5);
    #1 check("R1", "ready after reset", int'(req_ready_o), 1);
  endtask

  task automatic t_fill_set();
    // R6 R4 R2: empty set 5 fills ways 0..3 in order
    for (int i = 0; i < 4; i++) issue("R6", i + 1, 5, 1, i);
  endtask

  task automatic t_hits();
    issue("R3", 3, 5, 0, 2);
    issue("R3", 1, 5, 0, 0);
  endtask

  task automatic t_fifo();
    // R7: pointer 0 despite recent hit on way 0
    issue("R7", 9, 5, 1, 0);
    issue("R7", 10, 5, 1, 1);
    issue("R7", 1, 5, 1, 2);
  endtask

  task automatic t_sets();
    // R2 R8: same tag elsewhere is separate; set 5 pointer untouched
    issue("R8", 1, 6, 1, 0);
    issue("R8", 11, 5, 1, 3);
    issue("R2", 1, 6, 0, 0);
  endtask

  task automatic t_back_to_back();
    logic [BADDR_W-1:0] a;
    a = mk(20, 7);
    @(negedge clk);
    req_valid = 1'b1;
    req_baddr = a;
    #1 check("R5", "ready first", int'(req_ready_o), 1);
    @(negedge clk);
    check_out("R5", 7, 1, 0, a);
    #1 check("R5", "ready second", int'(req_ready_o), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check_out("R5", 7, 0, 0, a);
    @(negedge clk);
    check("R10", "rdq_valid idle", int'(rdq_valid_o), 0);
    check("R10", "mem_valid idle", int'(mem_valid_o), 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rdq_ready = 1'b0;
    req_valid = 1'b1;
    req_baddr = mk(21, 7);
    #1 check("R9", "ready no room", int'(req_ready_o), 0);
    @(negedge clk);
    check("R9", "no entry while stalled", int'(rdq_valid_o), 0);
    check("R9", "no fill while stalled", int'(mem_valid_o), 0);
    rdq_ready = 1'b1;
    mem_ready = 1'b0;
    #1 check("R9", "ready miss mem busy", int'(req_ready_o), 0);
    @(negedge clk);
    check("R9", "no entry mem busy", int'(rdq_valid_o), 0);
    req_valid = 1'b0;
    issue("R9", 20, 7, 0, 0);
    mem_ready = 1'b1;
    issue("R9", 21, 7, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_fill_set();
    t_hits();
    t_fifo();
    t_sets();
    t_back_to_back();
    t_stall();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule